// File: doc/BRIEF.md
# Tributary Jitter Smoothing Loop

This block takes the bursty, gapped bit stream of a single DS1 or E1 tributary and re-times it onto an evenly spaced output strobe. Incoming bits are stored in a small elastic buffer whenever the gapped input enable is high. A phase accumulator running on the system clock produces the output enable. The fill level of the buffer, measured against its midpoint, is the phase error of an all-digital loop. A proportional-plus-integral filter turns that error into the accumulator increment. A mode input picks the nominal increment for DS1 or E1 rates. Two shift amounts set the proportional and integral gains, and with them the loop bandwidth and damping.

Pointer adjustments upstream produce sudden phase steps. When a step is signalled by the pointer-event strobe, the loop can drop to first order for a provisioned number of cycles. During that time the integral path is frozen, so the step does not wind the integrator and the output wander stays small. A configuration bit keeps the loop in second order permanently. While an alarm request is held, every output bit is forced to one, and the output keeps its smoothed rate. The block sets a sticky slip flag whenever the buffer overruns or runs dry, and recentres the buffer when that happens.

Top module: `jitter_smoother`

## Requirements
- R1: While the reset input is low, out_en, out_data, slip and fo_active are all 0.
- R2: The output enable is the carry of an NCO_W-bit phase accumulator that adds the increment on every clock. With zero phase error and a zero integrator, the increment is floor(rate * 2^NCO_W / SYS_HZ), with rate 1,544,000 when cfg_mode is 0 (DS1) and 2,048,000 when cfg_mode is 1 (E1). out_en is high for the single cycle after each carry.
- R3: The output bits on successive out_en pulses are the written input bits in write order. They are preceded by DEPTH/2 filler bits that are present after reset.
- R4: While ais_req is high, out_data is 1 on every out_en pulse, whatever the input bits are. The out_en rate is unchanged.
- R5: The phase error is fill - DEPTH/2, as a signed number. The increment is nominal + ((err <<< KP_BASE) >>> cfg_kp_shift) + (integ >>> cfg_ki_shift). On each output tick the integrator adds err <<< KI_BASE and saturates at the limits of INT_W bits. The increment is clamped to the range 1 to 2^(NCO_W-1).
- R6: When cfg_force_second is 0, a ptr_evt pulse loads a timer with cfg_fo_len. fo_active is then high for exactly cfg_fo_len cycles, starting the cycle after the strobe. A new strobe reloads the timer. A length of 0 gives no first-order interval.
- R7: When cfg_force_second is 1, ptr_evt is ignored and fo_active stays 0.
- R8: While fo_active is high, the integrator holds its value and only the proportional path acts. When the timer expires, the integrator continues from the held value.
- R9: A write into a full buffer (without a read) or a read from an empty buffer sets slip. The same event moves the read pointer so that the fill becomes DEPTH/2. slip stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 1 | 0 = DS1 nominal rate, 1 = E1 nominal rate |
| cfg_force_second | input | 1 | 1 keeps the loop second order at all times |
| cfg_fo_len | input | FO_W | First-order interval in clock cycles |
| cfg_kp_shift | input | SH_W | Right shift applied to the proportional term |
| cfg_ki_shift | input | SH_W | Right shift applied to the integral term |
| in_en | input | 1 | Gapped input clock enable, one bit per high cycle |
| in_data | input | 1 | Input bit, taken when in_en is high |
| ptr_evt | input | 1 | One-cycle strobe marking a pointer adjustment |
| ais_req | input | 1 | Forces all-ones output while high |
| out_en | output | 1 | Smoothed output clock enable |
| out_data | output | 1 | Output bit, valid with out_en |
| slip | output | 1 | Sticky buffer overrun or underrun flag |
| fo_active | output | 1 | High while the loop runs first order |

## Verification
A wrong increment or a corrupted accumulator shows up as a wrong count of out_en pulses. Over a few thousand cycles, a single unit of increment error changes the count, so the bench counts pulses exactly against a computed figure. A fill-level or pointer fault misorders the output bits on the very next pulses, or raises slip within one buffer depth of reads. A timer fault changes the width of fo_active on the cycle after the strobe. An integrator that is not frozen changes how fast the output rate follows a fast input, so the bench compares that against a loop with the integrator running.

// File: rtl/jsm_pkg.sv
package jsm_pkg;
  typedef enum logic {MODE_DS1 = 1'b0, MODE_E1 = 1'b1} trib_mode_e;

  localparam int unsigned DS1_HZ = 1544000;
  localparam int unsigned E1_HZ  = 2048000;

  // Nominal accumulator step for a given line rate.
  function automatic logic [31:0] nominal_step(input int unsigned rate_hz,
                                               input int unsigned sys_hz,
                                               input int unsigned acc_w);
    logic [63:0] num;
    num = 64'(rate_hz) << acc_w;
    return 32'(num / 64'(sys_hz));
  endfunction
endpackage

// File: rtl/jsm_elastic_buf.sv
module jsm_elastic_buf #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          wr_en,
  input  logic          wr_data,
  input  logic          rd_en,
  input  logic          ais,
  output logic          rd_valid,
  output logic          rd_data,
  output logic [AW:0]   fill,
  output logic          slip
);
  logic [DEPTH-1:0] mem;
  logic [AW:0] wptr, rptr, wptr_n, rptr_n;
  logic        rd_data_n, slip_n, ovf, unf;

  assign fill = wptr - rptr;

  always_comb begin
    wptr_n    = wr_en ? wptr + 1'b1 : wptr;
    rptr_n    = rd_en ? rptr + 1'b1 : rptr;
    ovf       = wr_en && !rd_en && (fill == (AW+1)'(DEPTH));
    unf       = rd_en && (fill == '0);
    if (ovf || unf) rptr_n = wptr_n - (AW+1)'(HALF);
    slip_n    = slip | ovf | unf;
    rd_data_n = rd_data;
    if (rd_en) rd_data_n = ais ? 1'b1 : mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr     <= '0;
      rptr     <= (AW+1)'(2*DEPTH - HALF);
      rd_valid <= 1'b0;
      rd_data  <= 1'b0;
      slip     <= 1'b0;
    end else begin
      wptr     <= wptr_n;
      rptr     <= rptr_n;
      rd_valid <= rd_en;
      rd_data  <= rd_data_n;
      slip     <= slip_n;
    end
  end
endmodule

// File: rtl/jsm_loop_filter.sv
module jsm_loop_filter #(
  parameter int NCO_W   = 20,
  parameter int INT_W   = 20,
  parameter int PE_W    = 6,
  parameter int KP_BASE = 8,
  parameter int KI_BASE = 6,
  parameter int SH_W    = 4
) (
  input  logic                    clk,
  input  logic                    rst_ni,
  input  logic                    tick,
  input  logic                    freeze,
  input  logic signed [PE_W-1:0]  err,
  input  logic [SH_W-1:0]         kp_shift,
  input  logic [SH_W-1:0]         ki_shift,
  input  logic [NCO_W-1:0]        nom,
  output logic [NCO_W-1:0]        inc,
  output logic signed [INT_W-1:0] integ
);
  localparam int CW = NCO_W + INT_W + 2;
  localparam logic signed [CW-1:0] I_MAX   = $signed((CW'(1) << (INT_W-1)) - CW'(1));
  localparam logic signed [CW-1:0] I_MIN   = -I_MAX - CW'(1);
  localparam logic signed [CW-1:0] INC_MAX = $signed(CW'(1) << (NCO_W-1));
  localparam logic signed [CW-1:0] INC_MIN = $signed(CW'(1));

  logic signed [CW-1:0] err_w, p_term, i_term, raw, isum;
  logic signed [INT_W-1:0] integ_n;

  always_comb begin
    err_w  = CW'(err);
    p_term = (err_w <<< KP_BASE) >>> kp_shift;
    i_term = CW'(integ) >>> ki_shift;
    raw    = $signed(CW'(nom)) + p_term + i_term;
    if (raw < INC_MIN)      inc = NCO_W'(INC_MIN);
    else if (raw > INC_MAX) inc = NCO_W'(INC_MAX);
    else                    inc = NCO_W'(raw);

    isum = CW'(integ) + (err_w <<< KI_BASE);
    integ_n = integ;
    if (tick && !freeze) begin
      if (isum > I_MAX)      integ_n = INT_W'(I_MAX);
      else if (isum < I_MIN) integ_n = INT_W'(I_MIN);
      else                   integ_n = INT_W'(isum);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) integ <= '0;
    else         integ <= integ_n;
  end
endmodule

// File: rtl/jsm_nco.sv
module jsm_nco #(
  parameter int NCO_W = 20
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic [NCO_W-1:0] inc,
  output logic             tick
);
  logic [NCO_W-1:0] acc;
  logic [NCO_W:0]   sum;

  always_comb begin
    sum  = {1'b0, acc} + {1'b0, inc};
    tick = sum[NCO_W];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) acc <= '0;
    else         acc <= sum[NCO_W-1:0];
  end
endmodule

// File: rtl/jsm_order_timer.sv
module jsm_order_timer #(
  parameter int FO_W = 16
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic            evt,
  input  logic            force_second,
  input  logic [FO_W-1:0] len,
  output logic            active
);
  logic [FO_W-1:0] cnt, cnt_n;

  always_comb begin
    if (evt && !force_second) cnt_n = len;
    else if (cnt != '0)       cnt_n = cnt - 1'b1;
    else                      cnt_n = cnt;
  end

  assign active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else         cnt <= cnt_n;
  end
endmodule

// File: rtl/jitter_smoother.sv
module jitter_smoother
  import jsm_pkg::*;
#(
  parameter int SYS_HZ  = 50000000,
  parameter int DEPTH   = 16,
  parameter int NCO_W   = 20,
  parameter int INT_W   = 20,
  parameter int KP_BASE = 8,
  parameter int KI_BASE = 6,
  parameter int FO_W    = 16,
  parameter int SH_W    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_mode,
  input  logic            cfg_force_second,
  input  logic [FO_W-1:0] cfg_fo_len,
  input  logic [SH_W-1:0] cfg_kp_shift,
  input  logic [SH_W-1:0] cfg_ki_shift,
  input  logic            in_en,
  input  logic            in_data,
  input  logic            ptr_evt,
  input  logic            ais_req,
  output logic            out_en,
  output logic            out_data,
  output logic            slip,
  output logic            fo_active
);
  localparam int AW   = $clog2(DEPTH);
  localparam int PE_W = AW + 2;
  localparam int HALF = DEPTH / 2;
  localparam logic [NCO_W-1:0] NOM_DS1 = NCO_W'(nominal_step(DS1_HZ, SYS_HZ, NCO_W));
  localparam logic [NCO_W-1:0] NOM_E1  = NCO_W'(nominal_step(E1_HZ,  SYS_HZ, NCO_W));

  logic [1:0]              rst_sync;
  logic                    rst_ni;
  logic                    tick;
  logic [AW:0]             fill;
  logic signed [PE_W-1:0]  err;
  logic [NCO_W-1:0]        nom, inc;
  logic signed [INT_W-1:0] integ_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  assign nom = (trib_mode_e'(cfg_mode) == MODE_E1) ? NOM_E1 : NOM_DS1;
  assign err = $signed({1'b0, fill}) - $signed(PE_W'(HALF));

  jsm_elastic_buf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_ni(rst_ni), .wr_en(in_en), .wr_data(in_data),
    .rd_en(tick), .ais(ais_req), .rd_valid(out_en), .rd_data(out_data),
    .fill(fill), .slip(slip)
  );

  jsm_order_timer #(.FO_W(FO_W)) u_tmr (
    .clk(clk), .rst_ni(rst_ni), .evt(ptr_evt),
    .force_second(cfg_force_second), .len(cfg_fo_len), .active(fo_active)
  );

  jsm_loop_filter #(
    .NCO_W(NCO_W), .INT_W(INT_W), .PE_W(PE_W),
    .KP_BASE(KP_BASE), .KI_BASE(KI_BASE), .SH_W(SH_W)
  ) u_lf (
    .clk(clk), .rst_ni(rst_ni), .tick(tick), .freeze(fo_active), .err(err),
    .kp_shift(cfg_kp_shift), .ki_shift(cfg_ki_shift), .nom(nom),
    .inc(inc), .integ(integ_val)
  );

  jsm_nco #(.NCO_W(NCO_W)) u_nco (
    .clk(clk), .rst_ni(rst_ni), .inc(inc), .tick(tick)
  );
endmodule

// File: rtl/jitter_smoother_chk.sv
module jitter_smoother_chk #(
  parameter int DEPTH = 16,
  parameter int INT_W = 20,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic                    clk,
  input logic                    rst_ni,
  input logic                    ais_req,
  input logic                    out_en,
  input logic                    out_data,
  input logic                    cfg_force_second,
  input logic                    fo_active,
  input logic signed [INT_W-1:0] integ,
  input logic                    slip,
  input logic [AW:0]             fill
);
  // R2: the accumulator step never exceeds half its range
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_ni)
    out_en |=> !out_en);

  // R4
  a_r4_ais_ones: assert property (@(posedge clk) disable iff (!rst_ni)
    ais_req |=> (!out_en || out_data));

  // R7
  a_r7_force_blocks: assert property (@(posedge clk) disable iff (!rst_ni)
    (cfg_force_second && !fo_active) |=> !fo_active);

  // R8
  a_r8_integ_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    fo_active |=> $stable(integ));

  // R9
  a_r9_slip_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    slip |=> slip);

  // R9: recentring keeps the fill within the buffer
  a_r9_fill_bounded: assert property (@(posedge clk) disable iff (!rst_ni)
    fill <= (AW+1)'(DEPTH));
endmodule

bind jitter_smoother jitter_smoother_chk #(.DEPTH(DEPTH), .INT_W(INT_W)) u_chk (
  .clk(clk), .rst_ni(rst_ni), .ais_req(ais_req), .out_en(out_en),
  .out_data(out_data), .cfg_force_second(cfg_force_second),
  .fo_active(fo_active), .integ(integ_val), .slip(slip), .fill(fill)
);

// File: tb/jitter_smoother_test.sv
module jitter_smoother_test;
  localparam int NCO_W  = 20;
  localparam int SYS_HZ = 50000000;

  typedef struct packed {
    logic        e1;
    logic        ais;
    logic [1:0]  pat;
    logic [15:0] ncyc;
    logic [15:0] exp_ticks;
  } vec_t;

  // Expected tick count = floor(ncyc * step / 2^20), step 32380 (DS1) or 42949 (E1)
  localparam vec_t VECS [5] = '{
    '{1'b0, 1'b0, 2'd0, 16'd5000, 16'd154},
    '{1'b1, 1'b0, 2'd1, 16'd5000, 16'd204},
    '{1'b0, 1'b1, 2'd2, 16'd3000, 16'd92},
    '{1'b1, 1'b1, 2'd0, 16'd3000, 16'd122},
    '{1'b1, 1'b0, 2'd2, 16'd3000, 16'd122}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_mode, cfg_force_second, in_en, in_data, ptr_evt, ais_req;
  logic [15:0] cfg_fo_len;
  logic [3:0]  cfg_kp_shift, cfg_ki_shift;
  logic        out_en, out_data, slip, fo_active;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  jitter_smoother uut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
    .cfg_force_second(cfg_force_second), .cfg_fo_len(cfg_fo_len),
    .cfg_kp_shift(cfg_kp_shift), .cfg_ki_shift(cfg_ki_shift),
    .in_en(in_en), .in_data(in_data), .ptr_evt(ptr_evt), .ais_req(ais_req),
    .out_en(out_en), .out_data(out_data), .slip(slip), .fo_active(fo_active)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_en = 1'b0; in_data = 1'b0; ptr_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint step_of(input logic e1);
    longint rate;
    rate = e1 ? 64'd2048000 : 64'd1544000;
    return (rate << NCO_W) / SYS_HZ;
  endfunction

  task automatic run_fast(input logic force_so, output int ticks);
    cfg_mode = 1'b0; cfg_force_second = force_so; cfg_fo_len = 16'hFFFF;
    cfg_kp_shift = 4'd0; cfg_ki_shift = 4'd0; ais_req = 1'b0;
    do_reset();
    ticks = 0;
    ptr_evt = 1'b1;
    for (int i = 0; i < 1500; i++) begin
      in_en = (i % 28 == 0); in_data = 1'b1;
      @(negedge clk);
      ptr_evt = 1'b0;
      if (out_en) ticks++;
    end
    in_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int fo_cnt;
    int t_so, t_fo;
    cfg_mode = 1'b0; cfg_force_second = 1'b1; cfg_fo_len = 16'd0;
    cfg_kp_shift = 4'd4; cfg_ki_shift = 4'd8; ais_req = 1'b0;
    in_en = 1'b0; in_data = 1'b0; ptr_evt = 1'b0; rst_n = 1'b0;

    // R1: outputs in reset
    in_en = 1'b1; in_data = 1'b1; ais_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_en == 1'b0,    "R1", "out_en in reset", out_en, 0);
    chk(out_data == 1'b0,  "R1", "out_data in reset", out_data, 0);
    chk(slip == 1'b0,      "R1", "slip in reset", slip, 0);
    chk(fo_active == 1'b0, "R1", "fo_active in reset", fo_active, 0);
    ais_req = 1'b0;

    // Vector table: balanced feed, R2 rate, R3 ordering, R4 alarm
    for (int r = 0; r < 5; r++) begin
      longint acc, sum, step;
      int ticks, bad, e;
      int q[$];
      logic [14:0] lfsr;
      logic b, c;
      cfg_mode = VECS[r].e1; cfg_force_second = 1'b1;
      cfg_kp_shift = 4'd4; cfg_ki_shift = 4'd8;
      ais_req = 1'b0;
      do_reset();
      ais_req = VECS[r].ais;
      step = step_of(VECS[r].e1);
      acc = 0; ticks = 0; bad = 0; lfsr = 15'h1;
      q.delete();
      repeat (8) q.push_back(2);
      for (int i = 0; i < int'(VECS[r].ncyc); i++) begin
        sum = acc + step;
        c = (sum >> NCO_W) != 0;
        acc = sum & ((64'd1 << NCO_W) - 1);
        case (VECS[r].pat)
          2'd0:    b = i[0];
          2'd1:    b = lfsr[14] ^ lfsr[13];
          default: b = 1'b0;
        endcase
        if (c && VECS[r].pat == 2'd1) lfsr = {lfsr[13:0], b};
        in_en = c; in_data = b;
        @(negedge clk);
        if (out_en) begin
          ticks++;
          if (q.size() == 0) bad++;
          else begin
            e = q.pop_front();
            if (VECS[r].ais) begin
              if (out_data !== 1'b1) bad++;
            end else if (e != 2 && out_data !== e[0]) bad++;
          end
        end
        if (c) q.push_back(int'(b));
      end
      in_en = 1'b0;
      if (VECS[r].ais) begin
        chk(ticks == int'(VECS[r].exp_ticks), "R4", "tick count with alarm", ticks, VECS[r].exp_ticks);
        chk(bad == 0, "R4", "non-one bits under alarm", bad, 0);
      end else begin
        chk(ticks == int'(VECS[r].exp_ticks), "R2", "tick count", ticks, VECS[r].exp_ticks);
        chk(bad == 0, "R3", "out-of-order bits", bad, 0);
      end
      chk(slip == 1'b0, "R9", "no slip on balanced feed", slip, 0);
    end

    // R6: timer length and reload
    cfg_force_second = 1'b0; cfg_fo_len = 16'd7; ais_req = 1'b0;
    do_reset();
    chk(fo_active == 1'b0, "R6", "idle before strobe", fo_active, 0);
    fo_cnt = 0;
    ptr_evt = 1'b1;
    @(negedge clk); fo_cnt += int'(fo_active); ptr_evt = 1'b0;
    repeat (20) @(negedge clk) fo_cnt += int'(fo_active);
    chk(fo_cnt == 7, "R6", "first-order cycles", fo_cnt, 7);

    fo_cnt = 0;
    ptr_evt = 1'b1;
    @(negedge clk); fo_cnt += int'(fo_active); ptr_evt = 1'b0;
    @(negedge clk); fo_cnt += int'(fo_active);
    @(negedge clk); fo_cnt += int'(fo_active); ptr_evt = 1'b1;
    @(negedge clk); fo_cnt += int'(fo_active); ptr_evt = 1'b0;
    repeat (20) @(negedge clk) fo_cnt += int'(fo_active);
    chk(fo_cnt == 10, "R6", "first-order cycles after reload", fo_cnt, 10);

    cfg_fo_len = 16'd0; fo_cnt = 0;
    ptr_evt = 1'b1;
    @(negedge clk); fo_cnt += int'(fo_active); ptr_evt = 1'b0;
    repeat (10) @(negedge clk) fo_cnt += int'(fo_active);
    chk(fo_cnt == 0, "R6", "zero-length interval", fo_cnt, 0);

    // R7: forced second order ignores the strobe
    cfg_force_second = 1'b1; cfg_fo_len = 16'd9; fo_cnt = 0;
    ptr_evt = 1'b1;
    @(negedge clk); fo_cnt += int'(fo_active); ptr_evt = 1'b0;
    repeat (20) @(negedge clk) fo_cnt += int'(fo_active);
    chk(fo_cnt == 0, "R7", "strobe ignored when forced", fo_cnt, 0);

    // R5 R8: a running integrator follows a fast input better than a frozen one
    run_fast(1'b1, t_so);
    run_fast(1'b0, t_fo);
    chk(t_so > t_fo, "R5 R8", "ticks integrator running vs frozen", t_so, t_fo + 1);

    // R9: overflow sets slip, which stays set
    cfg_force_second = 1'b1; cfg_kp_shift = 4'd4; cfg_ki_shift = 4'd8;
    cfg_mode = 1'b0; ais_req = 1'b0;
    do_reset();
    in_en = 1'b1; in_data = 1'b1;
    repeat (40) @(negedge clk);
    in_en = 1'b0;
    chk(slip == 1'b1, "R9", "slip after overflow", slip, 1);
    repeat (300) @(negedge clk);
    chk(slip == 1'b1, "R9", "slip sticky", slip, 1);

    // R9: underflow sets slip
    do_reset();
    repeat (100) @(negedge clk);
    chk(slip == 1'b0, "R9", "no slip while draining", slip, 0);
    repeat (700) @(negedge clk);
    chk(slip == 1'b1, "R9", "slip after underflow", slip, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule